// File: doc/BRIEF.md
# Big-Endian External Bus Unit

This block sits between a 16-bit processor core and its external memory and I/O space. The core hands it a single word request: read or write, memory or I/O, a byte address and, for writes, a data word. The block then drives a registered address bus, a data bus with a separate output enable, and exactly one of four strobes: memory read, memory write, I/O read or I/O write. While the transfer is in progress it holds a stall line high toward the core. The access stays open until the addressed device answers on a ready input. When ready is never held back, the transfer takes one slot. A slow device adds one wait state for each cycle that ready stays low.

Memory is organised as two byte lanes in big-endian order. The byte at the even address travels on data bits 15..8. The byte at the following odd address travels on bits 7..0. For this reason, every word access must start on an even address. A request for an odd address is refused: the block raises a one-cycle error flag and starts no bus cycle. Cycles in which the core makes no external request, as happens for register-only instructions, leave all strobes and the output enable low.

Top module: `ebu_bus_unit`

## Requirements
- R1: After synchronous reset, all four strobes, stall, data_oe, rsp_valid and misalign_err are 0, and addr_bus is 0.
- R2: An accepted request with req_io=0 and req_write=0 at an even address makes mem_rd the only active strobe in the next cycle, with addr_bus equal to the requested address.
- R3: An accepted request with req_io=0 and req_write=1 at an even address makes mem_wr the only active strobe in the next cycle, with data_oe=1 and data_out equal to the request's write word.
- R4: An accepted even-address request with req_io=1 selects io_rd when req_write=0 and io_wr when req_write=1, with addr_bus equal to the requested address.
- R5: At most one of mem_rd, mem_wr, io_rd and io_wr is high in any cycle.
- R6: Once raised, the strobe and stall stay high through every cycle in which ready is low, and both drop in the cycle after ready is sampled high. A device that inserts N wait states therefore sees the strobe for N+1 cycles.
- R7: rsp_valid pulses for exactly one cycle, in the cycle after ready ends an access. For a read, rsp_rdata then holds the word sampled from data_in on that edge, with the even-address byte in bits 15..8 (bytes 07h at 0040h and 85h at 0041h read as 0785h).
- R8: A request whose address bit 0 is 1 produces a one-cycle misalign_err pulse in the next cycle, with no strobe and no stall. Every strobed access carries an even address.
- R9: data_oe is high exactly while mem_wr or io_wr is high. In every other cycle data_out is 0.
- R10: A request presented while stall is high is ignored. addr_bus holds its value for the whole access, and no new strobe follows the access unless a request arrives after stall drops.
- R11: With req_valid low, all strobes stay low and addr_bus stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core requests an external word access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 16 | Byte address of the word |
| req_wdata | input | 16 | Word to write |
| stall | output | 1 | Core must hold while an access is open |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Word returned by the last read |
| misalign_err | output | 1 | Odd-address request refused |
| addr_bus | output | 16 | External address bus |
| data_out | output | 16 | External data bus, write direction |
| data_oe | output | 1 | Enable for driving data_out onto the bus |
| data_in | input | 16 | External data bus, read direction |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| ready | input | 1 | Device has completed the current transfer |

## Verification
The bench tries all four access kinds with a device that answers after zero to three wait states. Measuring how long each strobe is held separates a correct wait count from an early or late release. Reads from a byte-lane memory whose contents follow an arithmetic pattern, together with write-then-readback pairs, show whether the even byte lands in the upper half of the word. Odd addresses in both spaces, requests made in the middle of an access, and idle stretches show that refused or stray requests never reach the strobes or the address bus.

// File: rtl/ebu_pkg.sv
`timescale 1ns/1ps
package ebu_pkg;
  localparam int NUM_STROBE = 4;

  // encoding follows {req_io, req_write}
  typedef enum logic [1:0] {
    K_MEM_RD = 2'd0,
    K_MEM_WR = 2'd1,
    K_IO_RD  = 2'd2,
    K_IO_WR  = 2'd3
  } kind_t;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_BUSY = 1'b1
  } state_t;
endpackage

// File: rtl/ebu_req_decode.sv
`timescale 1ns/1ps
module ebu_req_decode
  import ebu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              idle,
  output logic              start,
  output logic              misalign,
  output kind_t             kind
);
  localparam int OFS_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic odd;

  generate
    if (LANES > 1) begin : g_align
      assign odd = |req_addr[OFS_W-1:0];
    end else begin : g_no_align
      assign odd = 1'b0;
    end
  endgenerate

  // R8: odd word address is refused, R10: only taken while idle
  assign start    = req_valid & idle & ~odd;
  assign misalign = req_valid & idle & odd;
  assign kind     = kind_t'({req_io, req_write});
endmodule

// File: rtl/ebu_seq.sv
`timescale 1ns/1ps
module ebu_seq
  import ebu_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  misalign,
  input  kind_t                 kind,
  input  logic                  ready,
  output logic [NUM_STROBE-1:0] strobes,
  output logic                  busy,
  output logic                  idle,
  output logic                  complete,
  output logic                  done,
  output logic                  err
);
  state_t                state_q;
  logic [NUM_STROBE-1:0] strb_q;
  logic                  done_q;
  logic                  err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      strb_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= misalign;                       // R8
      case (state_q)
        S_IDLE: begin
          if (start) begin
            strb_q  <= NUM_STROBE'(1) << kind;  // R2 R3 R4 R5
            state_q <= S_BUSY;
          end
        end
        S_BUSY: begin
          if (ready) begin                      // R6: wait states until ready
            strb_q  <= '0;
            done_q  <= 1'b1;                    // R7
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign strobes  = strb_q;
  assign busy     = (state_q == S_BUSY);
  assign idle     = ~busy;
  assign complete = busy & ready;
  assign done     = done_q;
  assign err      = err_q;
endmodule

// File: rtl/ebu_datapath.sv
`timescale 1ns/1ps
module ebu_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              complete,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] addr_bus,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic [DATA_W-1:0] rdata
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rd_q;
  logic              oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      oe_q   <= 1'b0;
    end else if (start) begin
      addr_q <= req_addr;          // R2 R4: held for the whole access (R10)
      wd_q   <= req_wdata;
      oe_q   <= req_write;         // R9
    end else if (complete) begin
      addr_q <= '0;                // R11: bus rests at zero
      oe_q   <= 1'b0;
      if (!oe_q) rd_q <= din;      // R7: even byte already in upper lane
    end
  end

  assign addr_bus = addr_q;
  assign data_oe  = oe_q;
  assign data_out = oe_q ? wd_q : '0;
  assign rdata    = rd_q;
endmodule

// File: rtl/ebu_bus_unit.sv
`timescale 1ns/1ps
module ebu_bus_unit
  import ebu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              stall,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              misalign_err,
  output logic [ADDR_W-1:0] addr_bus,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic [DATA_W-1:0] data_in,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  input  logic              ready
);
  localparam int LANES = DATA_W / BYTE_W;

  logic                  start;
  logic                  misalign;
  kind_t                 kind;
  logic [NUM_STROBE-1:0] strobes;
  logic                  busy;
  logic                  idle;
  logic                  complete;

  ebu_req_decode #(
    .ADDR_W(ADDR_W),
    .LANES (LANES)
  ) u_dec (
    .req_valid(req_valid),
    .req_write(req_write),
    .req_io   (req_io),
    .req_addr (req_addr),
    .idle     (idle),
    .start    (start),
    .misalign (misalign),
    .kind     (kind)
  );

  ebu_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .misalign(misalign),
    .kind    (kind),
    .ready   (ready),
    .strobes (strobes),
    .busy    (busy),
    .idle    (idle),
    .complete(complete),
    .done    (rsp_valid),
    .err     (misalign_err)
  );

  ebu_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .complete (complete),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .din      (data_in),
    .addr_bus (addr_bus),
    .data_out (data_out),
    .data_oe  (data_oe),
    .rdata    (rsp_rdata)
  );

  assign stall  = busy;                 // R6
  assign mem_rd = strobes[K_MEM_RD];
  assign mem_wr = strobes[K_MEM_WR];
  assign io_rd  = strobes[K_IO_RD];
  assign io_wr  = strobes[K_IO_WR];
endmodule

// File: rtl/ebu_bus_unit_chk.sv
`timescale 1ns/1ps
module ebu_bus_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic              rsp_valid,
  input logic              misalign_err,
  input logic [ADDR_W-1:0] addr_bus,
  input logic              data_oe,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              io_rd,
  input logic              io_wr,
  input logic              ready
);
  localparam int LANES = DATA_W / BYTE_W;
  localparam int OFS_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [3:0] strb;
  logic       any_strb;
  assign strb     = {io_wr, io_rd, mem_wr, mem_rd};
  assign any_strb = |strb;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb)); // R5

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (any_strb && !ready) |=> ($stable(strb) && stall)); // R6

  AST_READY_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (any_strb && ready) |=> (!any_strb && !stall)); // R6

  AST_OE_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
    data_oe == (mem_wr || io_wr)); // R9

  AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (rst)
    misalign_err |-> (!any_strb && !stall)); // R8

  AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (rst)
    any_strb |-> (addr_bus[OFS_W-1:0] == '0)); // R8

  AST_RSP_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(any_strb && ready)); // R7

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (stall && $past(stall)) |-> $stable(addr_bus)); // R10
endmodule

bind ebu_bus_unit ebu_bus_unit_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .BYTE_W(BYTE_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .stall       (stall),
  .rsp_valid   (rsp_valid),
  .misalign_err(misalign_err),
  .addr_bus    (addr_bus),
  .data_oe     (data_oe),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .io_rd       (io_rd),
  .io_wr       (io_wr),
  .ready       (ready)
);

// File: tb/ebu_bus_unit_test.sv
`timescale 1ns/1ps
module ebu_bus_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_io = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        stall, rsp_valid, misalign_err, data_oe;
  logic [15:0] rsp_rdata, addr_bus, data_out;
  logic [15:0] data_in;
  logic        mem_rd, mem_wr, io_rd, io_wr;
  logic        ready;

  int compared = 0;
  int mismatched = 0;
  int waits = 0;
  int wcnt = 0;

  logic [7:0]  mem   [256];
  logic [15:0] ioreg [16];

  always #10 clk = ~clk;   // 50 MHz

  ebu_bus_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .stall(stall), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .misalign_err(misalign_err), .addr_bus(addr_bus), .data_out(data_out),
    .data_oe(data_oe), .data_in(data_in), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr), .ready(ready)
  );

  function automatic logic [7:0] pat8(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  function automatic logic [15:0] pat_word(input int a);
    if (a == 16'h0040) return 16'h0785;
    return {pat8(a), pat8(a + 1)};
  endfunction

  logic any_strb;
  assign any_strb = mem_rd | mem_wr | io_rd | io_wr;

  // device model: byte-lane memory, even byte on the upper lane
  always_comb begin
    ready   = any_strb && (wcnt == waits);
    data_in = '0;
    if (mem_rd)     data_in = {mem[addr_bus[7:0]], mem[addr_bus[7:0] + 8'd1]};
    else if (io_rd) data_in = ioreg[addr_bus[4:1]];
  end

  always @(posedge clk) begin
    if (rst) begin
      wcnt <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= pat8(i);
      mem[8'h40] <= 8'h07;
      mem[8'h41] <= 8'h85;
      for (int i = 0; i < 16; i++) ioreg[i] <= 16'hA000 + 16'(i * 3);
    end else begin
      if (!any_strb || ready) wcnt <= 0;
      else wcnt <= wcnt + 1;
      if (ready && mem_wr) begin
        mem[addr_bus[7:0]]        <= data_out[15:8];
        mem[addr_bus[7:0] + 8'd1] <= data_out[7:0];
      end
      if (ready && io_wr) ioreg[addr_bus[4:1]] <= data_out;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit io, input logic [15:0] a,
                        input logic [15:0] wd, input int w,
                        input logic [15:0] exp_rd, input bit intrude);
    logic [3:0] got, exp;
    int n;
    string tag;
    waits = w;
    tag = io ? "R4" : (wr ? "R3" : "R2");
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_io = io; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    got = {io_wr, io_rd, mem_wr, mem_rd};
    exp = 4'b0001 << {io, wr};
    chk(got == exp, tag, 32'(got), 32'(exp));
    chk(addr_bus == a, tag, 32'(addr_bus), 32'(a));
    chk(stall == 1'b1, "R6", 32'(stall), 32'd1);
    chk(data_oe == wr, "R9", 32'(data_oe), 32'(wr));
    if (wr) chk(data_out == wd, "R3", 32'(data_out), 32'(wd));
    n = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!any_strb) break;
      n++;
      chk(addr_bus == a && stall, "R10", 32'(addr_bus), 32'(a));
      if (intrude && n == 2) begin
        req_valid = 1'b1; req_write = ~wr; req_io = ~io; req_addr = a ^ 16'h0010;
      end
    end
    req_valid = 1'b0;
    chk(n == w + 1, "R6", 32'(n), 32'(w + 1));
    chk(!stall && rsp_valid, "R7", {stall, rsp_valid}, 32'b01);
    chk(!data_oe && data_out == 16'h0, "R9", 32'(data_out), 32'h0);
    if (!wr) chk(rsp_rdata == exp_rd, "R7", 32'(rsp_rdata), 32'(exp_rd));
    @(negedge clk);
    chk(!any_strb && !rsp_valid, "R10", {any_strb, rsp_valid}, 32'h0);
  endtask

  task automatic odd_req(input bit io, input bit wr, input logic [15:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_io = io; req_write = wr; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(misalign_err && !any_strb && !stall, "R8",
        {misalign_err, any_strb, stall}, 32'b100);
    @(negedge clk);
    chk(!misalign_err && !any_strb, "R8", {misalign_err, any_strb}, 32'h0);
  endtask

  initial begin
    #(20 * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(!any_strb && !stall && !data_oe && !rsp_valid && !misalign_err && addr_bus == 0,
        "R1", {any_strb, stall, data_oe, rsp_valid, misalign_err}, 32'h0);

    // R11 idle with no requests
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(!any_strb && addr_bus == 0 && !data_oe, "R11", 32'(addr_bus), 32'h0);
    end

    // R7 big-endian example word
    access(1'b0, 1'b0, 16'h0040, 16'h0, 0, 16'h0785, 1'b0);

    // sweep: wait states x access kinds (R2 R3 R4 R6 R7 R9)
    for (int w = 0; w < 4; w++) begin
      for (int i = 0; i < 6; i++) begin
        int ra, wa;
        logic [15:0] wd;
        ra = 2 * (i * 5 + w);
        wa = 16'h0080 + 2 * (i + 6 * w);
        wd = 16'(16'hC300 ^ (w * 256 + i * 17));
        access(1'b0, 1'b0, 16'(ra), 16'h0, w, pat_word(ra), 1'b0);
        access(1'b1, 1'b0, 16'(wa), wd, w, 16'h0, 1'b0);
        chk(mem[wa] == wd[15:8] && mem[wa + 1] == wd[7:0], "R7",
            {mem[wa], mem[wa + 1]}, 32'(wd));
        access(1'b0, 1'b0, 16'(wa), 16'h0, w, wd, 1'b0);
        access(1'b0, 1'b1, 16'(2 * i), 16'h0, w, 16'hA000 + 16'(i * 3), 1'b0);
        access(1'b1, 1'b1, 16'(2 * (i + 8)), wd ^ 16'h00FF, w, 16'h0, 1'b0);
        access(1'b0, 1'b1, 16'(2 * (i + 8)), 16'h0, w, wd ^ 16'h00FF, 1'b0);
      end
    end

    // R10 requests during a long access are ignored
    access(1'b0, 1'b0, 16'h0022, 16'h0, 3, pat_word(16'h22), 1'b1);
    access(1'b1, 1'b1, 16'h0004, 16'h1234, 2, 16'h0, 1'b1);
    access(1'b0, 1'b1, 16'h0004, 16'h0, 0, 16'h1234, 1'b0);

    // R8 odd addresses in both spaces
    odd_req(1'b0, 1'b0, 16'h0041);
    odd_req(1'b0, 1'b1, 16'h00FF);
    odd_req(1'b1, 1'b0, 16'h0003);
    odd_req(1'b1, 1'b1, 16'hC349);
    chk(mem[8'hFF] == pat8(255), "R8", 32'(mem[8'hFF]), 32'(pat8(255)));

    // R11 idle again
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!any_strb && !stall && addr_bus == 0, "R11", 32'(addr_bus), 32'h0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule